// File: doc/BRIEF.md
# UART Host Register Bank

This block is the byte-wide register file that a host processor sees when it talks to a 16550-compatible serial port. Eight byte registers sit behind a 3-bit offset. Separate read and write strobes access them. Behind the bank sit a receive FIFO and a transmit FIFO, neither of which lives here. The bank drives their push, pop and clear pulses and reads their occupancy counts. Toward the serial engine it presents the line control byte, the modem control byte, the 16-bit baud divisor, the interrupt enable bits and the stored FIFO control byte.

The bank owns the side effects of host accesses. These are: banking the divisor latch over the first two offsets, popping the receive FIFO, clearing sticky line errors and modem deltas on read, decoding the FIFO control byte, and keeping the transmit-empty interrupt flag. Interrupt prioritisation is done by a neighbouring block. That block returns its 4-bit identification code, and the bank forwards the code through the identification offset.

Top module: `uart_regbank`

## Requirements
- R1: When line control bit 7 is 1, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte; `divisor_o` is {high, low}; in this state no transmit push or receive pop occurs.
- R2: With line control bit 7 at 0, a write to offset 1 stores only bits 3:0 as interrupt enables; reading offset 1 returns them with bits 7:4 as 0.
- R3: With line control bit 7 at 0, a write to offset 0 pulses `tx_push_o` with the byte on `tx_data_o`, unless `tx_count_i` equals FIFO_DEPTH, and always clears `tx_empty_flag_o`; a `tx_drained_i` pulse sets the flag again.
- R4: With line control bit 7 at 0, reading offset 0 while `rx_count_i` is 0 returns 0xFA and does not pop; otherwise it pulses `rx_pop_o` and returns `rx_data_i`.
- R5: A write to offset 2 whose bit 0 differs from the stored FIFO-enable bit pulses both `rx_clear_o` and `tx_clear_o` and sets `tx_empty_flag_o`; bit 1 pulses `rx_clear_o`, bit 2 pulses `tx_clear_o`; `fcr_o` keeps bits 0, 3, 6, 7 and holds bits 1, 2, 4, 5 at 0.
- R6: Reading offset 5 returns bit 0 = (`rx_count_i` != 0), bit 1 overrun, bit 2 parity, bit 3 framing, bit 4 break, bits 5 and 6 = (`tx_count_i` < FIFO_DEPTH), bit 7 = `rx_fifo_err_i`; bits 1 to 4 are sticky and are cleared by that read.
- R7: `rx_valid_i` pulses `rx_push_o` when `rx_count_i` < FIFO_DEPTH; when the count equals FIFO_DEPTH the byte is not pushed and the overrun bit is set.
- R8: After reset the line control, modem control, interrupt enable, FIFO control, divisor and scratch values read 0, line errors are 0, modem status reads 0x30 (with CTS and DSR high and RI and DCD low at the pins), and `tx_empty_flag_o` is 1.
- R9: Writes to offsets 5 and 6 change nothing; offset 7 is a read/write scratch byte.
- R10: Offset 6 reads {DCD, RI, DSR, CTS, delta DCD, RI trailing edge, delta DSR, delta CTS}. Status follows the pins one cycle late, or follows the modem control bits when bit 4 is set (CTS from bit 1, DSR from bit 0, RI from bit 2, DCD from bit 3). The deltas are sticky and cleared by the read. RI sets its flag only on a 1 to 0 change.
- R11: Reading offset 2 returns {FIFO-enable, FIFO-enable, 2'b00, `iid_i`}; when `iid_i` is 4'b0010 (transmit empty) that read clears `tx_empty_flag_o`.
- R12: Side effects of a read happen only in the cycle in which `rd_i` is high; `rdata_o` is registered, valid the cycle after the strobe, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Write byte |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read byte |
| rx_valid_i | input | 1 | Received byte offered by the serial engine |
| rx_push_o | output | 1 | Push into receive FIFO |
| rx_data_i | input | 8 | Oldest receive FIFO byte |
| rx_count_i | input | CNT_W | Receive FIFO occupancy |
| rx_pop_o | output | 1 | Pop receive FIFO |
| rx_clear_o | output | 1 | Empty receive FIFO |
| rx_par_err_i | input | 1 | Parity error pulse |
| rx_frm_err_i | input | 1 | Framing error pulse |
| rx_brk_i | input | 1 | Break detected pulse |
| rx_fifo_err_i | input | 1 | FIFO error level |
| tx_push_o | output | 1 | Push into transmit FIFO |
| tx_data_o | output | 8 | Byte to push |
| tx_count_i | input | CNT_W | Transmit FIFO occupancy |
| tx_clear_o | output | 1 | Empty transmit FIFO |
| tx_drained_i | input | 1 | Transmit FIFO has drained |
| cts_i | input | 1 | Clear-to-send pin |
| dsr_i | input | 1 | Data-set-ready pin |
| ri_i | input | 1 | Ring indicator pin |
| dcd_i | input | 1 | Carrier detect pin |
| iid_i | input | 4 | Interrupt identification from the priority block |
| lcr_o | output | 8 | Line control byte |
| mcr_o | output | 8 | Modem control byte |
| divisor_o | output | 16 | Baud divisor |
| ier_o | output | 4 | Interrupt enables |
| fcr_o | output | 8 | Stored FIFO control byte |
| tx_empty_flag_o | output | 1 | Transmit-empty interrupt flag |
| line_err_o | output | 4 | {break, framing, parity, overrun} |
| modem_delta_o | output | 4 | {dcd delta, ri trailing, dsr delta, cts delta} |

## Verification
A wrong sticky error or modem delta shows at offset 5 or 6 on the next read, and it shows even earlier on `line_err_o` and `modem_delta_o`, one cycle after the event. A wrong divisor-bank or FIFO-control decode shows in the same cycle as the access, as a spurious or missing push, pop or clear pulse. A corrupted transmit-empty flag surfaces on `tx_empty_flag_o` one cycle after the data write, drain or identification read that should have moved it. Read-path faults show as a wrong or unheld `rdata_o` one cycle after the strobe.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_IER  = 3'd1;
  localparam logic [2:0] OFS_IID  = 3'd2;
  localparam logic [2:0] OFS_LCR  = 3'd3;
  localparam logic [2:0] OFS_MCR  = 3'd4;
  localparam logic [2:0] OFS_LSR  = 3'd5;
  localparam logic [2:0] OFS_MSR  = 3'd6;
  localparam logic [2:0] OFS_SCR  = 3'd7;

  localparam logic [7:0] RX_FILLER     = 8'hFA;
  localparam logic [7:0] FCR_KEEP_MASK = 8'hC9;
  localparam logic [3:0] IID_TX_EMPTY  = 4'b0010;

  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } modem_t;

  localparam modem_t MODEM_RESET = '{dcd: 1'b0, ri: 1'b0, dsr: 1'b1, cts: 1'b1};
endpackage

// File: rtl/uart_rb_lsr.sv
module uart_rb_lsr (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ovr_set_i,
  input  logic       par_set_i,
  input  logic       frm_set_i,
  input  logic       brk_set_i,
  input  logic       rd_clr_i,
  output logic [3:0] err_o
);
  logic [3:0] err_q, set;

  assign set = {brk_set_i, frm_set_i, par_set_i, ovr_set_i};

  // new events win over a clearing read in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= '0;
    else         err_q <= (rd_clr_i ? 4'b0 : err_q) | set;
  end

  assign err_o = err_q;

  assert_overrun_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_set_i |=> err_o[0]);
  assert_read_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && set == 4'b0) |=> err_o == 4'b0);
endmodule

// File: rtl/uart_rb_msr.sv
module uart_rb_msr
  import uart_rb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       loop_i,
  input  logic [3:0] mcr_lines_i,
  input  modem_t     pins_i,
  input  logic       rd_clr_i,
  output logic [7:0] status_o,
  output logic [3:0] delta_o
);
  modem_t     eff, st_q;
  logic [3:0] delta_q, delta_n;

  always_comb begin
    if (loop_i) begin
      eff.cts = mcr_lines_i[1];
      eff.dsr = mcr_lines_i[0];
      eff.ri  = mcr_lines_i[2];
      eff.dcd = mcr_lines_i[3];
    end else begin
      eff = pins_i;
    end
    delta_n[0] = st_q.cts ^ eff.cts;
    delta_n[1] = st_q.dsr ^ eff.dsr;
    delta_n[2] = st_q.ri & ~eff.ri;
    delta_n[3] = st_q.dcd ^ eff.dcd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= MODEM_RESET;
      delta_q <= '0;
    end else begin
      st_q    <= eff;
      delta_q <= (rd_clr_i ? 4'b0 : delta_q) | delta_n;
    end
  end

  assign status_o = {st_q, delta_q};
  assign delta_o  = delta_q;

  assert_cts_delta_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q.cts != eff.cts) |=> delta_q[0]);
  assert_delta_read_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && delta_n == 4'b0) |=> delta_q == 4'b0);
endmodule

// File: rtl/uart_rb_fifo_ctl.sv
module uart_rb_fifo_ctl
  import uart_rb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fcr_wr_i,
  input  logic [7:0] wdata_i,
  input  logic       tx_wr_i,
  input  logic       tx_drained_i,
  input  logic       iid_rd_thre_i,
  output logic [7:0] fcr_o,
  output logic       rx_clear_o,
  output logic       tx_clear_o,
  output logic       thre_o
);
  logic [7:0] fcr_q;
  logic       thre_q, fe_chg;

  assign fe_chg     = fcr_wr_i && (wdata_i[0] != fcr_q[0]);
  assign rx_clear_o = fcr_wr_i && (wdata_i[1] || fe_chg);
  assign tx_clear_o = fcr_wr_i && (wdata_i[2] || fe_chg);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fcr_q  <= '0;
      thre_q <= 1'b1;
    end else begin
      if (fcr_wr_i) fcr_q <= wdata_i & FCR_KEEP_MASK;
      // data write disarms first; arming beats the id-read clear
      if (tx_wr_i)                     thre_q <= 1'b0;
      else if (fe_chg || tx_drained_i) thre_q <= 1'b1;
      else if (iid_rd_thre_i)          thre_q <= 1'b0;
    end
  end

  assign fcr_o  = fcr_q;
  assign thre_o = thre_q;

  assert_fe_change_arms_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fe_chg |=> thre_q);
  assert_data_disarms_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr_i |=> !thre_q);
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_rb_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       addr_i,
  input  logic [7:0]       wdata_i,
  input  logic             wr_i,
  input  logic             rd_i,
  output logic [7:0]       rdata_o,
  input  logic             rx_valid_i,
  output logic             rx_push_o,
  input  logic [7:0]       rx_data_i,
  input  logic [CNT_W-1:0] rx_count_i,
  output logic             rx_pop_o,
  output logic             rx_clear_o,
  input  logic             rx_par_err_i,
  input  logic             rx_frm_err_i,
  input  logic             rx_brk_i,
  input  logic             rx_fifo_err_i,
  output logic             tx_push_o,
  output logic [7:0]       tx_data_o,
  input  logic [CNT_W-1:0] tx_count_i,
  output logic             tx_clear_o,
  input  logic             tx_drained_i,
  input  logic             cts_i,
  input  logic             dsr_i,
  input  logic             ri_i,
  input  logic             dcd_i,
  input  logic [3:0]       iid_i,
  output logic [7:0]       lcr_o,
  output logic [7:0]       mcr_o,
  output logic [15:0]      divisor_o,
  output logic [3:0]       ier_o,
  output logic [7:0]       fcr_o,
  output logic             tx_empty_flag_o,
  output logic [3:0]       line_err_o,
  output logic [3:0]       modem_delta_o
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(FIFO_DEPTH);

  logic [7:0] lcr_q, dll_q, dlh_q, scr_q, rdata_q, rd_mux, msr_status;
  logic [4:0] mcr_q;
  logic [3:0] ier_q;
  logic       dlab, tx_wr, rx_nonempty, tx_not_full, rx_room, ovr_set;
  logic       lsr_rd, msr_rd, iid_rd_thre, fcr_wr;
  modem_t     pins;

  assign dlab        = lcr_q[7];
  assign rx_nonempty = (rx_count_i != '0);
  assign tx_not_full = (tx_count_i < DEPTH_C);
  assign rx_room     = (rx_count_i < DEPTH_C);

  assign tx_wr       = wr_i && addr_i == OFS_DATA && !dlab;
  assign tx_push_o   = tx_wr && tx_not_full;
  assign tx_data_o   = wdata_i;
  assign rx_pop_o    = rd_i && addr_i == OFS_DATA && !dlab && rx_nonempty;
  assign rx_push_o   = rx_valid_i && rx_room;
  assign ovr_set     = rx_valid_i && !rx_room;
  assign fcr_wr      = wr_i && addr_i == OFS_IID;
  assign lsr_rd      = rd_i && addr_i == OFS_LSR;
  assign msr_rd      = rd_i && addr_i == OFS_MSR;
  assign iid_rd_thre = rd_i && addr_i == OFS_IID && iid_i == IID_TX_EMPTY;

  assign pins = '{dcd: dcd_i, ri: ri_i, dsr: dsr_i, cts: cts_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcr_q <= '0;
      mcr_q <= '0;
      ier_q <= '0;
      dll_q <= '0;
      dlh_q <= '0;
      scr_q <= '0;
    end else if (wr_i) begin
      unique case (addr_i)
        OFS_DATA: if (dlab) dll_q <= wdata_i;
        OFS_IER:  if (dlab) dlh_q <= wdata_i; else ier_q <= wdata_i[3:0];
        OFS_LCR:  lcr_q <= wdata_i;
        OFS_MCR:  mcr_q <= wdata_i[4:0];
        OFS_SCR:  scr_q <= wdata_i;
        default:  ;
      endcase
    end
  end

  uart_rb_fifo_ctl u_fifo_ctl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fcr_wr_i      (fcr_wr),
    .wdata_i       (wdata_i),
    .tx_wr_i       (tx_wr),
    .tx_drained_i  (tx_drained_i),
    .iid_rd_thre_i (iid_rd_thre),
    .fcr_o         (fcr_o),
    .rx_clear_o    (rx_clear_o),
    .tx_clear_o    (tx_clear_o),
    .thre_o        (tx_empty_flag_o)
  );

  uart_rb_lsr u_lsr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ovr_set_i (ovr_set),
    .par_set_i (rx_par_err_i),
    .frm_set_i (rx_frm_err_i),
    .brk_set_i (rx_brk_i),
    .rd_clr_i  (lsr_rd),
    .err_o     (line_err_o)
  );

  uart_rb_msr u_msr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .loop_i      (mcr_q[4]),
    .mcr_lines_i (mcr_q[3:0]),
    .pins_i      (pins),
    .rd_clr_i    (msr_rd),
    .status_o    (msr_status),
    .delta_o     (modem_delta_o)
  );

  always_comb begin
    unique case (addr_i)
      OFS_DATA: rd_mux = dlab ? dll_q : (rx_nonempty ? rx_data_i : RX_FILLER);
      OFS_IER:  rd_mux = dlab ? dlh_q : {4'b0, ier_q};
      OFS_IID:  rd_mux = {fcr_o[0], fcr_o[0], 2'b00, iid_i};
      OFS_LCR:  rd_mux = lcr_q;
      OFS_MCR:  rd_mux = {3'b0, mcr_q};
      OFS_LSR:  rd_mux = {rx_fifo_err_i, tx_not_full, tx_not_full, line_err_o, rx_nonempty};
      OFS_MSR:  rd_mux = msr_status;
      default:  rd_mux = scr_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o   = rdata_q;
  assign lcr_o     = lcr_q;
  assign mcr_o     = {3'b0, mcr_q};
  assign divisor_o = {dlh_q, dll_q};
  assign ier_o     = ier_q;

  assert_rdata_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
  assert_filler_on_empty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == OFS_DATA && !dlab && rx_count_i == '0) |=> rdata_o == RX_FILLER);
  assert_dlab_no_fifo_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlab |-> (!tx_push_o && !rx_pop_o));
endmodule

// File: tb/uart_regbank_tb.sv
module uart_regbank_tb_top;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    addr = '0;
  logic [7:0]    wdata = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [7:0]    rdata;
  logic          rx_valid = 1'b0, rx_push;
  logic [7:0]    rx_data = '0;
  logic [CW-1:0] rx_count = '0, tx_count = '0;
  logic          rx_pop, rx_clear, tx_push, tx_clear;
  logic          par = 1'b0, frm = 1'b0, brk = 1'b0, ferr = 1'b0, drained = 1'b0;
  logic [7:0]    tx_data, lcr, mcr, fcr;
  logic          cts = 1'b1, dsr = 1'b1, ri = 1'b0, dcd = 1'b0;
  logic [3:0]    iid = 4'b0001, ier, lerr, mdelta;
  logic [15:0]   divisor;
  logic          thre;

  int n_run = 0, n_fail = 0;
  logic p_txpush, p_rxpop, p_rxclr, p_txclr;
  logic [7:0] p_txdata;

  always #10 clk = ~clk;

  uart_regbank #(.FIFO_DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .rdata_o(rdata), .rx_valid_i(rx_valid), .rx_push_o(rx_push), .rx_data_i(rx_data),
    .rx_count_i(rx_count), .rx_pop_o(rx_pop), .rx_clear_o(rx_clear),
    .rx_par_err_i(par), .rx_frm_err_i(frm), .rx_brk_i(brk), .rx_fifo_err_i(ferr),
    .tx_push_o(tx_push), .tx_data_o(tx_data), .tx_count_i(tx_count), .tx_clear_o(tx_clear),
    .tx_drained_i(drained), .cts_i(cts), .dsr_i(dsr), .ri_i(ri), .dcd_i(dcd), .iid_i(iid),
    .lcr_o(lcr), .mcr_o(mcr), .divisor_o(divisor), .ier_o(ier), .fcr_o(fcr),
    .tx_empty_flag_o(thre), .line_err_o(lerr), .modem_delta_o(mdelta)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    #1;
    p_txpush = tx_push; p_txdata = tx_data; p_rxclr = rx_clear; p_txclr = tx_clear;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1;
    p_rxpop = rx_pop;
    @(negedge clk);
    rd = 1'b0;
    v = rdata;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R8 lcr", lcr, 0); check("R8 mcr", mcr, 0); check("R8 fcr", fcr, 0);
    check("R8 divisor", divisor, 0); check("R8 ier", ier, 0); check("R8 thre", thre, 1);
    check("R8 line err", lerr, 0);
    bus_rd(3'd7, v); check("R8 scratch", v, 8'h00);
    bus_rd(3'd6, v); check("R8 msr", v, 8'h30);
    bus_rd(3'd5, v); check("R8 lsr", v, 8'h60);
  endtask

  task automatic t_dlab();
    logic [7:0] v;
    bus_wr(3'd3, 8'h83);
    bus_wr(3'd0, 8'h34); check("R1 no tx push under dlab", p_txpush, 0);
    bus_wr(3'd1, 8'h12);
    check("R1 divisor", divisor, 16'h1234);
    check("R1 ier untouched", ier, 0);
    rx_count = 5'd2; rx_data = 8'h99;
    bus_rd(3'd0, v); check("R1 dll read", v, 8'h34); check("R1 no pop", p_rxpop, 0);
    bus_rd(3'd1, v); check("R1 dlh read", v, 8'h12);
    rx_count = '0;
    bus_wr(3'd3, 8'h03);
    bus_rd(3'd1, v); check("R1 ier bank", v, 8'h00);
    check("R1 lcr out", lcr, 8'h03);
  endtask

  task automatic t_ier();
    logic [7:0] v;
    bus_wr(3'd1, 8'hFF);
    bus_rd(3'd1, v); check("R2 ier read", v, 8'h0F);
    check("R2 ier out", ier, 4'hF);
  endtask

  task automatic t_tx();
    logic [7:0] v;
    bus_wr(3'd0, 8'h55);
    check("R3 push", p_txpush, 1); check("R3 data", p_txdata, 8'h55);
    check("R3 disarm", thre, 0);
    @(negedge clk); drained = 1'b1; @(negedge clk); drained = 1'b0;
    check("R3 rearm", thre, 1);
    tx_count = 5'd16;
    bus_wr(3'd0, 8'h66);
    check("R3 full no push", p_txpush, 0); check("R3 full disarm", thre, 0);
    bus_rd(3'd5, v); check("R6 tx full bits", v, 8'h00);
    tx_count = '0;
  endtask

  task automatic t_rx();
    logic [7:0] v;
    bus_rd(3'd0, v); check("R4 filler", v, 8'hFA); check("R4 no pop empty", p_rxpop, 0);
    rx_count = 5'd3; rx_data = 8'hA5;
    bus_rd(3'd0, v); check("R4 pop", p_rxpop, 1); check("R4 data", v, 8'hA5);
    bus_rd(3'd5, v); check("R6 data ready", v, 8'h61);
    check("R12 hold", rdata, 8'h61);
    idle(); check("R12 hold later", rdata, 8'h61);
    rx_count = '0;
  endtask

  task automatic t_fcr();
    logic [7:0] v;
    bus_wr(3'd2, 8'h01);
    check("R5 fe change rx clr", p_rxclr, 1); check("R5 fe change tx clr", p_txclr, 1);
    check("R5 fe change arms", thre, 1); check("R5 fcr", fcr, 8'h01);
    bus_wr(3'd2, 8'h03);
    check("R5 rx clr only", p_rxclr, 1); check("R5 tx not clr", p_txclr, 0);
    check("R5 bit1 not stored", fcr, 8'h01);
    bus_wr(3'd2, 8'hF5);
    check("R5 rx not clr", p_rxclr, 0); check("R5 tx clr", p_txclr, 1);
    check("R5 masked store", fcr, 8'hC1);
    iid = 4'b0001;
    bus_rd(3'd2, v); check("R11 iid fmt", v, 8'hC1);
    bus_wr(3'd0, 8'h01);
    bus_wr(3'd2, 8'h00);
    check("R5 fe off clears", {p_rxclr, p_txclr}, 2'b11); check("R5 fe off arms", thre, 1);
  endtask

  task automatic t_lsr();
    logic [7:0] v;
    @(negedge clk);
    par = 1; frm = 1; brk = 1; rx_count = 5'd16; rx_valid = 1;
    #1 check("R7 full no push", rx_push, 0);
    @(negedge clk);
    par = 0; frm = 0; brk = 0; rx_valid = 0; rx_count = 5'd2;
    check("R7 overrun set", lerr, 4'hF);
    @(negedge clk); rx_valid = 1;
    #1 check("R7 push with room", rx_push, 1);
    @(negedge clk); rx_valid = 0; rx_count = '0;
    bus_rd(3'd5, v); check("R6 errors read", v, 8'h7E);
    bus_rd(3'd5, v); check("R6 cleared", v, 8'h60);
    ferr = 1;
    bus_rd(3'd5, v); check("R6 fifo err bit", v, 8'hE0);
    ferr = 0;
  endtask

  task automatic t_ro();
    logic [7:0] v;
    bus_wr(3'd5, 8'hFF); bus_wr(3'd6, 8'hFF);
    bus_rd(3'd5, v); check("R9 lsr ignores write", v, 8'h60);
    bus_rd(3'd6, v); check("R9 msr ignores write", v, 8'h30);
    bus_wr(3'd7, 8'hA7);
    bus_rd(3'd7, v); check("R9 scratch", v, 8'hA7);
  endtask

  task automatic t_msr();
    logic [7:0] v;
    @(negedge clk); cts = 0; idle();
    bus_rd(3'd6, v); check("R10 dcts", v, 8'h21);
    bus_rd(3'd6, v); check("R10 delta cleared", v, 8'h20);
    bus_wr(3'd4, 8'h10); idle();
    bus_rd(3'd6, v); check("R10 loop dsr", v, 8'h02);
    bus_wr(3'd4, 8'h1F); idle();
    bus_rd(3'd6, v); check("R10 loop all high", v, 8'hFB);
    bus_wr(3'd4, 8'h1B); idle();
    check("R10 delta out", mdelta, 4'h4);
    bus_rd(3'd6, v); check("R10 ri trailing", v, 8'hB4);
    bus_rd(3'd4, v); check("R10 mcr read", v, 8'h1B);
    bus_wr(3'd4, 8'h00); idle();
    bus_rd(3'd6, v); check("R10 back to pins", v, 8'h29);
    @(negedge clk); cts = 1; idle();
    bus_rd(3'd6, v); check("R10 cts return", v, 8'h31);
  endtask

  task automatic t_iid();
    logic [7:0] v;
    bus_wr(3'd0, 8'h11);
    @(negedge clk); drained = 1'b1; @(negedge clk); drained = 1'b0;
    iid = 4'b0001;
    bus_rd(3'd2, v); check("R11 other id keeps flag", thre, 1);
    iid = 4'b0010;
    bus_rd(3'd2, v); check("R11 iid read", v, 8'h02); check("R11 flag cleared", thre, 0);
    iid = 4'b0001;
  endtask

  initial begin : wd
    #(20 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_dlab();
    t_ier();
    t_tx();
    t_rx();
    t_fcr();
    t_lsr();
    t_ro();
    t_msr();
    t_iid();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule